// File: doc/BRIEF.md
# Dual-Channel IDE Interrupt and Routing Registers

This block is the small control plane of an expansion card that carries two IDE channels sharing one DMA engine and one host interrupt line. For each channel it keeps a latched interrupt-enable flag and a status bit. It merges the status bits into a single interrupt output to the host.

The interrupt-enable protocol has no data. Any write to a channel's enable address arms that channel. The first cycle of a read from the same address disarms it. The status bit is the channel's raw drive interrupt gated by its enable, so a floating line on an unused channel cannot raise the host interrupt. A routing byte selects which channel the DMA engine serves and opens the extended taskfile access window. The card also reports a fixed 4-bit identity code, one bit per word across four addresses.

Bus accesses are byte-wide and strobe-qualified. Read data is registered and appears one cycle after the first cycle of a read strobe.

Top module: `dual_ide_irq_regs`

## Requirements
- R1: After reset both channel enables are clear, the routing byte is 0x00, `host_irq`, `dma_chan_sel` and `tf_window_en` are low, and `bus_rdata` is 0x00.
- R2: A write of any data to 0x2200 sets the channel-1 enable, and a write to 0x3200 sets the channel-2 enable, effective at the clock edge of the write.
- R3: The first cycle of a read strobe at 0x2200 (channel 1) or 0x3200 (channel 2) clears that channel's enable and returns 0x00. If a write to the same address happens in that cycle, the write wins and the enable is set.
- R4: Each channel's status bit is a register loaded every cycle with its raw drive interrupt ANDed with the channel's enable value for the next cycle. Channel 1 status reads in bit 0 of 0x2290, channel 2 in bit 0 of 0x3290, and bits 7:1 read 0. A raw input on a disabled channel leaves its status at 0.
- R5: `host_irq` is high exactly when at least one channel status bit is set.
- R6: The routing byte at 0x0000 is readable and writable. Bit 0 drives `dma_chan_sel` (1 = channel 2, 0 = channel 1) and bit 5 drives `tf_window_en`. Writing 0x00 clears both outputs.
- R7: Bit 0 of the bytes at 0x2280, 0x2284, 0x2288 and 0x228C returns identity bits 0, 1, 2 and 3 of `CARD_ID` (default 3), with bits 7:1 zero.
- R8: `bus_rdata` is loaded only at the first cycle of a read strobe, which is detected as a rising strobe. It holds that value until the next such cycle. An address change while the strobe stays high causes no read side effect.
- R9: Reads of any other address return 0x00. Writes to any address other than the two enable addresses and 0x0000 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (14) | Byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| drv_irq_raw | input | 2 | Raw drive interrupts, bit 0 = channel 1 |
| host_irq | output | 1 | Combined interrupt to host |
| dma_chan_sel | output | 1 | DMA channel routing, 1 = channel 2 |
| tf_window_en | output | 1 | Extended taskfile window enable |

## Verification
The bound checker checks several rules on every cycle. An enable-address write must arm the channel at the next sample. A fresh read of the enable address with no write must disarm it. `host_irq` may only rise when a raw input was high and a channel was armed. Routing writes must reach the select outputs, and read data must stay unchanged while the strobe is held. Other behaviour shows only in the bench's scenarios. That covers the identity bit spread, the zero upper bits of status reads, and the write-over-read priority. It also covers the lack of any side effect when the address moves under a held strobe, and the silence of unmapped writes.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;
    localparam int DATA_W    = 8;
    localparam int NCH       = 2;
    localparam int ID_W      = 4;
    localparam int ROUTE_ADR = 'h0000;
    localparam int CH_BASE   = 'h2000;
    localparam int CH_STRIDE = 'h1000;
    localparam int EN_OFS    = 'h0200;
    localparam int ST_OFS    = 'h0290;
    localparam int ID_ADR    = 'h2280;
    localparam int ID_STEP   = 4;
    localparam int SEL_BIT   = 0;
    localparam int WIN_BIT   = 5;

    typedef struct packed {
        logic [NCH-1:0]  en_hit;
        logic [NCH-1:0]  st_hit;
        logic [ID_W-1:0] id_hit;
        logic            route_hit;
    } dec_t;
endpackage

// File: rtl/ide_addr_dec.sv
module ide_addr_dec
    import ide_irq_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              hit
);
    localparam logic [ADDR_W-1:0] ROUTE_A = ADDR_W'(ROUTE_ADR);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(CH_BASE + c * CH_STRIDE + EN_OFS);
        localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(CH_BASE + c * CH_STRIDE + ST_OFS);
        assign hit.en_hit[c] = (addr == EN_A);
        assign hit.st_hit[c] = (addr == ST_A);
    end

    for (genvar i = 0; i < ID_W; i++) begin : g_id
        localparam logic [ADDR_W-1:0] ID_A = ADDR_W'(ID_ADR + i * ID_STEP);
        assign hit.id_hit[i] = (addr == ID_A);
    end

    assign hit.route_hit = (addr == ROUTE_A);
endmodule

// File: rtl/ide_chan_irq.sv
module ide_chan_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic en_set,
    input  logic en_clr,
    input  logic raw,
    output logic en_o,
    output logic stat_o
);
    typedef struct packed {
        logic en;
        logic stat;
    } chan_t;

    chan_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (en_set)      s_d.en = 1'b1;
        else if (en_clr) s_d.en = 1'b0;
        s_d.stat = raw & s_d.en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign en_o   = s_q.en;
    assign stat_o = s_q.stat;
endmodule

// File: rtl/dual_ide_irq_regs.sv
module dual_ide_irq_regs
    import ide_irq_pkg::*;
#(
    parameter int              ADDR_W  = 14,
    parameter logic [ID_W-1:0] CARD_ID = 4'd3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [1:0]        drv_irq_raw,
    output logic              host_irq,
    output logic              dma_chan_sel,
    output logic              tf_window_en
);
    typedef struct packed {
        logic              rd_prev;
        logic [DATA_W-1:0] route;
        logic [DATA_W-1:0] rdata;
    } top_t;

    top_t q, d;
    dec_t hit;
    logic rd_pulse;
    logic [NCH-1:0] ch_en, ch_stat;

    ide_addr_dec #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .hit(hit));

    assign rd_pulse = bus_rd & ~q.rd_prev;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        ide_chan_irq u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_set (bus_wr & hit.en_hit[c]),
            .en_clr (rd_pulse & hit.en_hit[c]),
            .raw    (drv_irq_raw[c]),
            .en_o   (ch_en[c]),
            .stat_o (ch_stat[c])
        );
    end

    always_comb begin
        logic [DATA_W-1:0] mux;
        d         = q;
        d.rd_prev = bus_rd;
        if (bus_wr && hit.route_hit) d.route = bus_wdata;

        mux = '0;
        for (int c = 0; c < NCH; c++)
            if (hit.st_hit[c]) mux[0] = ch_stat[c];
        for (int i = 0; i < ID_W; i++)
            if (hit.id_hit[i]) mux[0] = CARD_ID[i];
        if (hit.route_hit) mux = q.route;

        if (rd_pulse) d.rdata = mux;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_rdata    = q.rdata;
    assign host_irq     = |ch_stat;
    assign dma_chan_sel = q.route[SEL_BIT];
    assign tf_window_en = q.route[WIN_BIT];
endmodule

// File: rtl/ide_irq_regs_chk.sv
module ide_irq_regs_chk #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic [1:0]        drv_irq_raw,
    input logic              host_irq,
    input logic              dma_chan_sel,
    input logic              tf_window_en,
    input logic [1:0]        ch_en
);
    localparam logic [ADDR_W-1:0] EN1_A = ADDR_W'('h2200);
    localparam logic [ADDR_W-1:0] EN2_A = ADDR_W'('h3200);
    localparam logic [ADDR_W-1:0] RT_A  = ADDR_W'('h0000);

    // R2
    arm_ch1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == EN1_A) |=> ch_en[0]);

    // R2
    arm_ch2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == EN2_A) |=> ch_en[1]);

    // R3
    disarm_ch1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_rd) && !bus_wr && bus_addr == EN1_A) |=> !ch_en[0]);

    // R5
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_irq) |-> ($past(|drv_irq_raw) && (|ch_en)));

    // R6
    route_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == RT_A) |=>
            (dma_chan_sel == $past(bus_wdata[0]) && tf_window_en == $past(bus_wdata[5])));

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && $past(bus_rd)) |=> $stable(bus_rdata));
endmodule

bind dual_ide_irq_regs ide_irq_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .drv_irq_raw  (drv_irq_raw),
    .host_irq     (host_irq),
    .dma_chan_sel (dma_chan_sel),
    .tf_window_en (tf_window_en),
    .ch_en        (ch_en)
);

// File: tb/tb_dual_ide_irq_regs.sv
module tb_dual_ide_irq_regs;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [13:0] bus_addr = '0;
    logic        bus_rd = 0, bus_wr = 0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [1:0]  drv_irq_raw = '0;
    logic        host_irq, dma_chan_sel, tf_window_en;

    int n_chk = 0, n_bad = 0;
    logic [7:0] q_exp[$];
    string      q_req[$];
    logic       rd_prev_tb = 0, cmp_now = 0;

    always #2 clk = ~clk;

    dual_ide_irq_regs dut (.*);

    // monitor: a rising read strobe produces one rdata result at the next sample
    always @(posedge clk) begin
        rd_prev_tb <= bus_rd;
        cmp_now    <= rst_n && bus_rd && !rd_prev_tb;
    end

    always @(negedge clk) begin
        if (cmp_now) begin
            n_chk++;
            if (q_exp.size() == 0) begin
                n_bad++;
                $display("FAIL R8: unexpected read result %h", bus_rdata);
            end else begin
                logic [7:0] e;
                string r;
                e = q_exp.pop_front();
                r = q_req.pop_front();
                if (bus_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: rdata actual %h expected %h", r, bus_rdata, e);
                end
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [13:0] a, input logic [7:0] v);
        @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [13:0] a, input logic [7:0] e, input string req);
        @(negedge clk); bus_addr = a; bus_rd = 1;
        q_exp.push_back(e); q_req.push_back(req);
        @(negedge clk); bus_rd = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk(host_irq, 0, "R1"); chk(dma_chan_sel, 0, "R1"); chk(tf_window_en, 0, "R1");
        chk(bus_rdata == 8'h00, 1, "R1");
        rd(14'h0000, 8'h00, "R1");
        // R4 raw inputs on disabled channels stay quiet
        drv_irq_raw = 2'b11;
        repeat (2) @(negedge clk);
        chk(host_irq, 0, "R4");
        rd(14'h2290, 8'h00, "R4");
        // R2 arm channel 1 with arbitrary data
        wr(14'h2200, 8'h5A);
        chk(host_irq, 1, "R2");
        rd(14'h2290, 8'h01, "R4");
        rd(14'h3290, 8'h00, "R4");
        // R3 read disarms
        rd(14'h2200, 8'h00, "R3");
        chk(host_irq, 0, "R3");
        // R2/R5 channel 2, then raw drops
        wr(14'h3200, 8'h00);
        chk(host_irq, 1, "R5");
        rd(14'h3290, 8'h01, "R4");
        drv_irq_raw = 2'b01;
        repeat (2) @(negedge clk);
        chk(host_irq, 0, "R5");
        drv_irq_raw = 2'b11;
        repeat (2) @(negedge clk);
        chk(host_irq, 1, "R5");
        // R8 held strobe moving onto the enable address has no side effect
        @(negedge clk); bus_addr = 14'h3290; bus_rd = 1;
        q_exp.push_back(8'h01); q_req.push_back("R8");
        @(negedge clk); bus_addr = 14'h3200;
        repeat (2) @(negedge clk);
        chk(host_irq, 1, "R8");
        chk(bus_rdata == 8'h01, 1, "R8");
        bus_rd = 0;
        rd(14'h3200, 8'h00, "R3");
        chk(host_irq, 0, "R3");
        // R3 write wins over read in the same cycle
        @(negedge clk); bus_addr = 14'h2200; bus_rd = 1; bus_wr = 1;
        q_exp.push_back(8'h00); q_req.push_back("R3");
        @(negedge clk); bus_rd = 0; bus_wr = 0;
        chk(host_irq, 1, "R3");
        rd(14'h2200, 8'h00, "R3");
        chk(host_irq, 0, "R3");
        // R6 routing byte
        wr(14'h0000, 8'h21);
        chk(dma_chan_sel, 1, "R6"); chk(tf_window_en, 1, "R6");
        rd(14'h0000, 8'h21, "R6");
        wr(14'h0000, 8'h20);
        chk(dma_chan_sel, 0, "R6"); chk(tf_window_en, 1, "R6");
        wr(14'h0000, 8'h00);
        chk(dma_chan_sel, 0, "R6"); chk(tf_window_en, 0, "R6");
        // R7 identity code 3, LSB first
        rd(14'h2280, 8'h01, "R7");
        rd(14'h2284, 8'h01, "R7");
        rd(14'h2288, 8'h00, "R7");
        rd(14'h228C, 8'h00, "R7");
        // R9 unmapped reads and writes
        rd(14'h2281, 8'h00, "R9");
        wr(14'h2290, 8'hFF);
        wr(14'h1234, 8'hFF);
        chk(host_irq, 0, "R9");
        chk(dma_chan_sel, 0, "R9"); chk(tf_window_en, 0, "R9");
        rd(14'h0000, 8'h00, "R9");
        repeat (3) @(negedge clk);
        if (q_exp.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL R8: actual %0d pending reads expected 0", q_exp.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule